// File: doc/BRIEF.md
# Lockable Patch Register File

This block sits at the bottom of the processor address space, in front of a boot program ROM and a cartridge ROM. While it is unlocked, it presents 32 word registers that can be written and, on request, read back. Its mode register chooses whether reads of the lowest 64 KB come from the boot ROM or from the cartridge. The boot ROM holds 32 KB and repeats once to fill that 64 KB.

Software fills six patch slots. Each slot uses three consecutive registers: a high address field, a low address word and a replacement data word. It then sets the lock bit in the mode register. From the next cycle the register window is gone. All reads go to the cartridge, and any cartridge word whose address matches an armed slot returns that slot's data instead of the ROM contents.

Reads are registered. The result appears on `rd_data` with `rd_valid` one cycle after the read strobe. The two ROMs sit outside the block. The block drives their word addresses and takes their data back combinationally in the same cycle.

Top module: `code_lock_regfile`

## Requirements
- R1: After reset, reads in the low window (bus_addr[23:16] == 0) return boot ROM data. The registers stay hidden from reads. `rd_valid` and `rd_data` reset to 0.
- R2: The boot ROM word address is bus_addr[14:1], so addresses 0x8000 to 0xFFFF repeat the contents of 0x0000 to 0x7FFF.
- R3: While unlocked, a word write (bus_word = 1) anywhere in the low window sets register bus_addr[5:1]. When mode bit 9 is set, a low-window read returns that register, so the 64-byte register set repeats through the window.
- R4: A byte write (bus_word = 0) takes its byte from bus_wdata[7:0]. An even address replaces bits [15:8] and an odd address replaces bits [7:0]. The other half keeps its value.
- R5: With mode bit 9 clear, the registers cannot be read. Low-window reads return ROM data.
- R6: While unlocked, mode bit 10 selects the source of low-window reads when registers are not readable: 0 selects the boot ROM and 1 selects the cartridge. Reads outside the low window always go to the cartridge, at word address bus_addr[21:1].
- R7: Any accepted write to register 1 leaves its bit 0 set, whatever the written value.
- R8: When a write leaves mode bit 8 set, the block locks on the next cycle. After that, reads in every range come from the cartridge, and register writes have no effect until reset.
- R9: On lock, slot k (k = 0..5) takes its word address {reg[2+3k][5:0], reg[3+3k][15:1]} and its data reg[4+3k]. Bits [15:6] of the high register and bit 0 of the low register are ignored.
- R10: When locked, a cartridge read whose bus_addr[21:1] equals a slot word address returns that slot's data. When several slots match, the lowest-numbered slot wins.
- R11: Before lock, slot register contents have no effect on cartridge reads. Reset disarms all slots.
- R12: `rd_valid` is high exactly in the cycle after a cycle with `bus_rd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Byte address of the access |
| bus_wdata | input | 16 | Write data; a byte write uses bits [7:0] |
| bus_word | input | 1 | 1 = word write, 0 = byte write |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 16 | Read result, valid one cycle after the strobe |
| rd_valid | output | 1 | Marks the cycle in which rd_data holds a fresh result |
| boot_addr | output | 14 | Boot ROM word address |
| boot_data | input | 16 | Boot ROM word, combinational from boot_addr |
| cart_addr | output | 21 | Cartridge ROM word address |
| cart_data | input | 16 | Cartridge ROM word, combinational from cart_addr |

## Verification
Each read result is due exactly one clock after its strobe. The bench raises the strobe on a falling edge and samples `rd_data` and `rd_valid` on the next falling edge, when exactly one rising edge has passed. A register write, the forced reset-request flag and the lock all take effect at the rising edge that samples the write. A read issued on the following falling edge therefore already sees the new state, and the bench checks the new state with exactly that read. Expected words come from arithmetic ROM models and from a slot table that the bench keeps itself. Sweeps cover the whole low window, all 32 registers through an alias, and every slot address together with its neighbours.

// File: rtl/clr_pkg.sv
package clr_pkg;
    parameter int ADDR_W        = 24;
    parameter int DATA_W        = 16;
    parameter int BYTE_W        = 8;
    parameter int REG_COUNT     = 32;
    parameter int SLOT_COUNT    = 6;
    parameter int WIN_AW        = 16;
    parameter int BOOT_WAW      = 14;
    parameter int SLOT_HI_W     = 6;
    parameter int SLOT_BASE     = 2;
    parameter int REGS_PER_SLOT = 3;
    parameter int LOCK_BIT      = 8;
    parameter int READ_BIT      = 9;
    parameter int CART_BIT      = 10;

    localparam int REG_IDX_W = $clog2(REG_COUNT);
    localparam int SLOT_WAW  = SLOT_HI_W + DATA_W - 1;

    typedef logic [DATA_W-1:0]   word_t;
    typedef logic [SLOT_WAW-1:0] slot_waddr_t;

    typedef struct packed {
        logic [REG_COUNT-1:0][DATA_W-1:0]    regs;
        logic [SLOT_COUNT-1:0][SLOT_WAW-1:0] slot_addr;
        logic [SLOT_COUNT-1:0][DATA_W-1:0]   slot_data;
        logic                                locked;
        logic                                rd_valid;
        logic [DATA_W-1:0]                   rd_data;
    } clr_state_t;
endpackage

// File: rtl/clr_lane_merge.sv
module clr_lane_merge
    import clr_pkg::*;
(
    input  word_t old_word,
    input  word_t wr_word,
    input  logic  full_word,
    input  logic  low_lane,
    output word_t new_word
);
    always_comb begin
        if (full_word) begin
            new_word = wr_word;
        end else if (low_lane) begin
            new_word = {old_word[DATA_W-1:BYTE_W], wr_word[BYTE_W-1:0]};
        end else begin
            new_word = {wr_word[BYTE_W-1:0], old_word[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/clr_slot_match.sv
module clr_slot_match
    import clr_pkg::*;
(
    input  slot_waddr_t                         probe,
    input  logic [SLOT_COUNT-1:0][SLOT_WAW-1:0] slot_addr,
    input  logic [SLOT_COUNT-1:0][DATA_W-1:0]   slot_data,
    input  logic                                armed,
    output logic                                hit,
    output word_t                               hit_data
);
    logic [SLOT_COUNT-1:0] eq;

    for (genvar k = 0; k < SLOT_COUNT; k++) begin : g_cmp
        assign eq[k] = armed && (probe == slot_addr[k]);
    end

    always_comb begin
        hit      = |eq;
        hit_data = '0;
        for (int k = SLOT_COUNT - 1; k >= 0; k--) begin
            if (eq[k]) begin
                hit_data = slot_data[k];
            end
        end
    end
endmodule

// File: rtl/code_lock_regfile.sv
module code_lock_regfile
    import clr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_word,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic [BOOT_WAW-1:0] boot_addr,
    input  logic [DATA_W-1:0]   boot_data,
    output logic [SLOT_WAW-1:0] cart_addr,
    input  logic [DATA_W-1:0]   cart_data
);
    clr_state_t st_q, st_d;

    logic [REG_IDX_W-1:0] reg_idx;
    logic                 low_win;
    word_t                merged_word;
    logic                 patch_hit;
    word_t                patch_word;

    // Signals brought out for the bound checker
    logic                                locked_w;
    word_t                               reg0_w;
    logic                                reg1_flag_w;
    logic [SLOT_COUNT-1:0][SLOT_WAW-1:0] slot_addr_w;

    assign reg_idx   = bus_addr[REG_IDX_W:1];
    assign low_win   = (bus_addr[ADDR_W-1:WIN_AW] == '0);
    assign boot_addr = bus_addr[BOOT_WAW:1];
    assign cart_addr = bus_addr[SLOT_WAW:1];

    clr_lane_merge u_merge (
        .old_word  (st_q.regs[reg_idx]),
        .wr_word   (bus_wdata),
        .full_word (bus_word),
        .low_lane  (bus_addr[0]),
        .new_word  (merged_word)
    );

    clr_slot_match u_match (
        .probe     (bus_addr[SLOT_WAW:1]),
        .slot_addr (st_q.slot_addr),
        .slot_data (st_q.slot_data),
        .armed     (st_q.locked),
        .hit       (patch_hit),
        .hit_data  (patch_word)
    );

    always_comb begin
        word_t wr_val;
        st_d          = st_q;
        st_d.rd_valid = bus_rd;
        wr_val        = merged_word;

        // read path, one register stage
        if (bus_rd) begin
            if (!st_q.locked && low_win && st_q.regs[0][READ_BIT]) begin
                st_d.rd_data = st_q.regs[reg_idx];
            end else if (!st_q.locked && low_win && !st_q.regs[0][CART_BIT]) begin
                st_d.rd_data = boot_data;
            end else if (patch_hit) begin
                st_d.rd_data = patch_word;
            end else begin
                st_d.rd_data = cart_data;
            end
        end

        // write path, closed once locked
        if (bus_wr && !st_q.locked && low_win) begin
            if (reg_idx == REG_IDX_W'(1)) begin
                wr_val[0] = 1'b1;
            end
            st_d.regs[reg_idx] = wr_val;
            if ((reg_idx == '0) && wr_val[LOCK_BIT]) begin
                st_d.locked = 1'b1;
                for (int k = 0; k < SLOT_COUNT; k++) begin
                    st_d.slot_addr[k] = {
                        st_q.regs[SLOT_BASE + REGS_PER_SLOT*k][SLOT_HI_W-1:0],
                        st_q.regs[SLOT_BASE + REGS_PER_SLOT*k + 1][DATA_W-1:1]
                    };
                    st_d.slot_data[k] = st_q.regs[SLOT_BASE + REGS_PER_SLOT*k + 2];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data     = st_q.rd_data;
    assign rd_valid    = st_q.rd_valid;
    assign locked_w    = st_q.locked;
    assign reg0_w      = st_q.regs[0];
    assign reg1_flag_w = st_q.regs[1][0];
    assign slot_addr_w = st_q.slot_addr;
endmodule

// File: rtl/clr_checks.sv
module clr_checks
    import clr_pkg::*;
(
    input logic                                clk,
    input logic                                rst_n,
    input logic                                bus_rd,
    input logic                                bus_wr,
    input logic [ADDR_W-1:WIN_AW]              addr_hi,
    input logic [REG_IDX_W-1:0]                addr_idx,
    input logic                                rd_valid,
    input logic [DATA_W-1:0]                   rd_data,
    input logic [DATA_W-1:0]                   boot_data,
    input logic                                locked,
    input logic [DATA_W-1:0]                   reg0,
    input logic                                reg1_flag,
    input logic [SLOT_COUNT-1:0][SLOT_WAW-1:0] slot_addr
);
    // R12
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rd_valid);

    // R12
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !rd_valid);

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R8
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(reg0));

    // R9
    slot_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(slot_addr));

    // R7
    reset_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !locked && addr_hi == '0 && addr_idx == REG_IDX_W'(1)) |=> reg1_flag);

    // R1
    boot_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !locked && addr_hi == '0 && !reg0[READ_BIT] && !reg0[CART_BIT])
        |=> rd_data == $past(boot_data));
endmodule

bind code_lock_regfile clr_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .addr_hi   (bus_addr[clr_pkg::ADDR_W-1:clr_pkg::WIN_AW]),
    .addr_idx  (bus_addr[clr_pkg::REG_IDX_W:1]),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .boot_data (boot_data),
    .locked    (locked_w),
    .reg0      (reg0_w),
    .reg1_flag (reg1_flag_w),
    .slot_addr (slot_addr_w)
);

// File: tb/code_lock_regfile_tb.sv
module code_lock_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_word;
    logic        bus_wr;
    logic        bus_rd;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [13:0] boot_addr;
    logic [15:0] boot_data;
    logic [20:0] cart_addr;
    logic [15:0] cart_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] s_hi  [6];
    logic [15:0] s_lo  [6];
    logic [15:0] s_dat [6];

    always #5 clk = ~clk;

    function automatic logic [15:0] boot_fn(input logic [13:0] wa);
        return {2'b10, wa};
    endfunction

    function automatic logic [15:0] cart_fn(input logic [20:0] wa);
        return wa[15:0] ^ {wa[20:16], 11'h2B3};
    endfunction

    assign boot_data = boot_fn(boot_addr);
    assign cart_data = cart_fn(cart_addr);

    code_lock_regfile u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_word  (bus_word),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .boot_addr (boot_addr),
        .boot_data (boot_data),
        .cart_addr (cart_addr),
        .cart_data (cart_data)
    );

    function automatic logic [15:0] boot_exp(input logic [23:0] a);
        return boot_fn(a[14:1]);
    endfunction

    function automatic logic [15:0] cart_exp(input logic [23:0] a);
        return cart_fn(a[21:1]);
    endfunction

    function automatic logic [23:0] slot_byte(input int k);
        return {2'b00, s_hi[k][5:0], s_lo[k][15:1], 1'b0};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [15:0] d, input logic word);
        bus_addr  = a;
        bus_wdata = d;
        bus_word  = word;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [23:0] a, output logic [15:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = rd_data;
        check("R12 rd_valid after strobe", {15'd0, rd_valid}, 16'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R12 actual=%h expected=%h", 16'd1, 16'd0);
        finish_run();
    end

    initial begin
        logic [15:0] d;
        logic [15:0] pat;
        bus_addr = '0; bus_wdata = '0; bus_word = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset rd_valid", {15'd0, rd_valid}, 16'd0);
        check("R1 reset rd_data", rd_data, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: sweep of the low window after reset
        for (int a = 0; a < 'h10000; a += 'h0202) begin
            rd(24'(a), d);
            check(a >= 'h8000 ? "R2 boot mirror" : "R1 boot read", d, boot_exp(24'(a)));
        end

        // R5: registers hidden while mode bit 9 is clear
        wr(24'h00000A, 16'h1234, 1'b1);
        check("R12 idle after write", {15'd0, rd_valid}, 16'd0);
        rd(24'h00000A, d);
        check("R5 write-only register", d, boot_exp(24'h00000A));

        // R3 / R7: fill registers, read back through an alias
        wr(24'h000000, 16'h0200, 1'b1);
        for (int i = 1; i < 32; i++) begin
            pat = 16'(i * 16'h0911) ^ 16'h3C5A;
            wr(24'(2 * i), pat, 1'b1);
        end
        rd(24'h000040, d);
        check("R3 mode register readback", d, 16'h0200);
        for (int i = 1; i < 32; i++) begin
            pat = 16'(i * 16'h0911) ^ 16'h3C5A;
            rd(24'(24'h004C40 + 2 * i), d);
            if (i == 1) check("R7 reset flag forced", d, pat | 16'h0001);
            else        check("R3 register readback", d, pat);
        end
        wr(24'h000002, 16'h0000, 1'b1);
        rd(24'h000002, d);
        check("R7 reset flag after zero write", d, 16'h0001);

        // R4: byte lanes
        wr(24'h000028, 16'h0000, 1'b1);
        wr(24'h000028, 16'h77AB, 1'b0);
        rd(24'h000028, d);
        check("R4 even byte upper lane", d, 16'hAB00);
        wr(24'h000029, 16'h66CD, 1'b0);
        rd(24'h000028, d);
        check("R4 odd byte lower lane", d, 16'hABCD);
        wr(24'h000001, 16'h00FF, 1'b0);
        rd(24'h000000, d);
        check("R4 byte write to mode", d, 16'h02FF);

        // R6: cartridge selected for the low window
        wr(24'h000000, 16'h0400, 1'b1);
        rd(24'h001234, d);
        check("R6 low window from cart", d, cart_exp(24'h001234));
        rd(24'h000000, d);
        check("R6 register hidden under cart", d, cart_exp(24'h000000));
        wr(24'h000000, 16'h0000, 1'b1);
        rd(24'h001234, d);
        check("R6 boot selected again", d, boot_exp(24'h001234));
        rd(24'h123456, d);
        check("R6 high address from cart", d, cart_exp(24'h123456));

        // slot table, slot 4 aliases slot 1 with bit 0 flipped
        for (int k = 0; k < 6; k++) begin
            s_hi[k]  = 16'hAB00 | 16'(k * 7 + 3);
            s_lo[k]  = 16'h0246 + 16'(k * 16'h1000) + ((k == 2) ? 16'd1 : 16'd0);
            s_dat[k] = 16'hD000 + 16'(k * 16'h0111);
        end
        s_hi[4] = s_hi[1];
        s_lo[4] = s_lo[1] ^ 16'h0001;
        for (int k = 0; k < 6; k++) begin
            wr(24'(2 * (2 + 3 * k)), s_hi[k], 1'b1);
            wr(24'(2 * (3 + 3 * k)), s_lo[k], 1'b1);
            wr(24'(2 * (4 + 3 * k)), s_dat[k], 1'b1);
        end
        for (int k = 0; k < 6; k++) begin
            rd(slot_byte(k), d);
            check("R11 no patch before lock", d, cart_exp(slot_byte(k)));
        end

        // R8: lock
        wr(24'h000000, 16'h0100, 1'b1);
        rd(24'h000000, d);
        check("R8 window gone after lock", d, cart_exp(24'h000000));
        rd(24'h00F00C, d);
        check("R8 low read from cart", d, cart_exp(24'h00F00C));
        wr(24'h000000, 16'h0200, 1'b1);
        wr(24'h000006, 16'h0000, 1'b1);
        rd(24'h000000, d);
        check("R8 write ignored when locked", d, cart_exp(24'h000000));

        // R9 / R10: patched reads
        for (int k = 0; k < 6; k++) begin
            rd(slot_byte(k), d);
            check(k == 4 ? "R10 lowest slot wins" : "R9 patched word", d, (k == 4) ? s_dat[1] : s_dat[k]);
            rd(slot_byte(k) + 24'd1, d);
            check("R9 odd byte address", d, (k == 4) ? s_dat[1] : s_dat[k]);
            rd(slot_byte(k) + 24'd2, d);
            check("R9 neighbour unpatched", d, cart_exp(slot_byte(k) + 24'd2));
        end

        // reset clears lock and slots
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(24'h000000, d);
        check("R1 boot after second reset", d, boot_exp(24'h000000));
        rd(slot_byte(0), d);
        check("R11 slots disarmed by reset", d, cart_exp(slot_byte(0)));

        finish_run();
    end
endmodule